// File: doc/BRIEF.md
# Inter-Processor Interrupt Register Block

This block lets processor cores interrupt one another through a small register bank on a single-cycle register bus. Every destination core has three word registers: a raise view, a clear view and a non-maskable raise register. One more raise/clear pair serves an external host pin. A sender writes its own source bit into the raise view of the destination. If the same write also carries the go bit, the destination receives a one-clock interrupt pulse. The receiver reads which sources are pending from either view. It retires a source by writing a 1 to that bit through the clear view.

Each destination keeps one sticky source vector, and both views read it. The raise view sets flags with write-1. The clear view clears them with write-1. Writing 0 to a bit changes nothing in either view. Pulses leave a register, so each one appears in the cycle after the accepted write. Read data is combinational from the current address.

Top module: `ipi_regblock`

## Requirements
- R1: After reset every source flag reads 0, and `core_irq`, `core_nmi` and `host_irq` are all low.
- R2: A write to the raise view of core c (word address c) with bit 0 = 1 drives `core_irq[c]` high for exactly the next clock cycle. Writes in consecutive cycles each produce their own pulse, and a write with bit 0 = 0 produces none.
- R3: A write to a raise view sets each source flag whose bit is 1 in data bits 4..31 (source s at bit 4+s). Flags written with 0 keep their value.
- R4: The raise view and the clear view of one destination return the same flag value in data bits 4..31.
- R5: A write to the clear view of core c (word address NUM_CORES+c) clears each flag whose data bit is 1 and leaves the others unchanged. It never produces a pulse, even when bit 0 = 1.
- R6: The host pair sits at word addresses 3*NUM_CORES (raise) and 3*NUM_CORES+1 (clear). It keeps its own flags with the same set and clear rules, and its go bit pulses `host_irq` for one cycle.
- R7: A write with bit 0 = 1 to the non-maskable register of core c (word address 2*NUM_CORES+c) drives `core_nmi[c]` high for exactly the next cycle.
- R8: Bits 3..0 of every read are 0, non-maskable registers always read 0, and unmapped addresses read 0. Writes to unmapped addresses change no flag and produce no pulse.
- R9: A bus cycle with `bus_sel` low, or a read, changes no flag and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| core_irq | output | NUM_CORES | One-cycle interrupt pulse per core |
| core_nmi | output | NUM_CORES | One-cycle non-maskable pulse per core |
| host_irq | output | 1 | One-cycle pulse to the external host pin |

## Verification
Several rules are checked on every cycle: each pulse follows a qualifying write, a raise write leaves its bits set, a clear write leaves its bits cleared, idle cycles hold all flags, and reserved read bits stay zero. Other behaviour can only be shown through the bench's scenarios. This covers aliasing between the two views, reads of non-maskable and unmapped words, the absence of pulses on clear-view writes, and the accumulated flag state after long mixed sequences. The bench follows that state with its own model across random traffic and directed corner cases.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int DATA_W  = 32;
   localparam int GO_BIT  = 0;
   localparam int SRC_LSB = 4;

   // word address of the raise view for channel ch (host channel is ch == ncores)
   function automatic int addr_gen(int ch, int ncores);
      return (ch < ncores) ? ch : 3 * ncores;
   endfunction

   // word address of the clear view for channel ch
   function automatic int addr_ack(int ch, int ncores);
      return (ch < ncores) ? ncores + ch : 3 * ncores + 1;
   endfunction

   // word address of the non-maskable raise register of core c
   function automatic int addr_nmi(int c, int ncores);
      return 2 * ncores + c;
   endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 6
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_CORES:0] gen_hit,
   output logic [NUM_CORES:0] ack_hit,
   output logic [NUM_CORES-1:0] nmi_hit
);
   for (genvar ch = 0; ch <= NUM_CORES; ch++) begin : g_ch
      assign gen_hit[ch] = (addr == ADDR_W'(addr_gen(ch, NUM_CORES)));
      assign ack_hit[ch] = (addr == ADDR_W'(addr_ack(ch, NUM_CORES)));
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_nmi
      assign nmi_hit[c] = (addr == ADDR_W'(addr_nmi(c, NUM_CORES)));
   end
endmodule

// File: rtl/ipi_src_bank.sv
module ipi_src_bank #(
   parameter int NUM_SRC = 28
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic               clr_en,
   input  logic               go,
   input  logic [NUM_SRC-1:0] src,
   output logic [NUM_SRC-1:0] flags,
   output logic               pulse
);
   logic [NUM_SRC-1:0] set_mask;
   logic [NUM_SRC-1:0] clr_mask;

   assign set_mask = set_en ? src : '0;
   assign clr_mask = clr_en ? src : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         pulse <= 1'b0;
      end else begin
         // a set applied in the same cycle as a clear takes priority
         flags <= (flags & ~clr_mask) | set_mask;
         pulse <= set_en & go;
      end
   end
endmodule

// File: rtl/ipi_pulse_reg.sv
module ipi_pulse_reg #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] fire,
   output logic [WIDTH-1:0] pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= '0;
      else        pulse <= fire;
   end
endmodule

// File: rtl/ipi_regblock.sv
module ipi_regblock
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_SRC   = 28,
   parameter int ADDR_W    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_CORES-1:0] core_irq,
   output logic [NUM_CORES-1:0] core_nmi,
   output logic                 host_irq
);
   localparam int NCH = NUM_CORES + 1;

   if (NUM_CORES < 1) begin : g_bad_cores
      $error("ipi_regblock: NUM_CORES must be at least 1");
   end
   if (NUM_SRC < 1 || NUM_SRC > DATA_W - SRC_LSB) begin : g_bad_src
      $error("ipi_regblock: NUM_SRC must lie in 1..%0d", DATA_W - SRC_LSB);
   end
   if ((1 << ADDR_W) < 3 * NUM_CORES + 2) begin : g_bad_addr
      $error("ipi_regblock: ADDR_W too narrow for the register map");
   end

   logic                        wr;
   logic                        go;
   logic [NUM_SRC-1:0]          src;
   logic [NCH-1:0]              gen_hit;
   logic [NCH-1:0]              ack_hit;
   logic [NUM_CORES-1:0]        nmi_hit;
   logic [NCH-1:0][NUM_SRC-1:0] flags_all;
   logic [NCH-1:0]              ch_pulse;
   logic                        unused_wdata;

   assign wr           = bus_sel & bus_we;
   assign go           = bus_wdata[GO_BIT];
   assign src          = bus_wdata[SRC_LSB +: NUM_SRC];
   assign unused_wdata = ^bus_wdata;

   ipi_decode #(
      .NUM_CORES(NUM_CORES),
      .ADDR_W   (ADDR_W)
   ) u_decode (
      .addr   (bus_addr),
      .gen_hit(gen_hit),
      .ack_hit(ack_hit),
      .nmi_hit(nmi_hit)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_bank
      ipi_src_bank #(
         .NUM_SRC(NUM_SRC)
      ) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .set_en(wr & gen_hit[ch]),
         .clr_en(wr & ack_hit[ch]),
         .go    (go),
         .src   (src),
         .flags (flags_all[ch]),
         .pulse (ch_pulse[ch])
      );
   end

   assign core_irq = ch_pulse[NUM_CORES-1:0];
   assign host_irq = ch_pulse[NUM_CORES];

   ipi_pulse_reg #(
      .WIDTH(NUM_CORES)
   ) u_nmi (
      .clk  (clk),
      .rst_n(rst_n),
      .fire ({NUM_CORES{wr & go}} & nmi_hit),
      .pulse(core_nmi)
   );

   always_comb begin
      bus_rdata = '0;
      for (int ch = 0; ch < NCH; ch++) begin
         if (gen_hit[ch] || ack_hit[ch]) begin
            bus_rdata[SRC_LSB +: NUM_SRC] = flags_all[ch];
         end
      end
   end
endmodule

// File: rtl/ipi_regblock_chk.sv
module ipi_regblock_chk
   import ipi_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_SRC   = 28,
   parameter int ADDR_W    = 6
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                bus_sel,
   input logic                                bus_we,
   input logic [ADDR_W-1:0]                   bus_addr,
   input logic [DATA_W-1:0]                   bus_wdata,
   input logic [DATA_W-1:0]                   bus_rdata,
   input logic [NUM_CORES-1:0]                core_irq,
   input logic [NUM_CORES-1:0]                core_nmi,
   input logic                                host_irq,
   input logic [NUM_CORES:0][NUM_SRC-1:0]     flags_all
);
   localparam int NCH = NUM_CORES + 1;
   localparam logic [DATA_W-1:0] RD_MASK = DATA_W'({NUM_SRC{1'b1}}) << SRC_LSB;

   logic               wr;
   logic [NUM_SRC-1:0] src;
   logic               unused_chk;

   assign wr         = bus_sel & bus_we;
   assign src        = bus_wdata[SRC_LSB +: NUM_SRC];
   assign unused_chk = ^bus_wdata;

   // R8: only the source field may ever read non-zero
   p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~RD_MASK) == '0);

   // R9: no write, no flag change
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(flags_all));

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(addr_gen(ch, NUM_CORES));
      localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(addr_ack(ch, NUM_CORES));

      // R3: raise-view write leaves every written 1 set
      p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && bus_addr == A_GEN) |=> ((flags_all[ch] & $past(src)) == $past(src)));

      // R5: clear-view write leaves every written 1 cleared
      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && bus_addr == A_ACK) |=> ((flags_all[ch] & $past(src)) == '0));
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(addr_gen(c, NUM_CORES));
      localparam logic [ADDR_W-1:0] A_NMI = ADDR_W'(addr_nmi(c, NUM_CORES));

      // R2: go write produces a pulse next cycle
      p_irq_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && bus_addr == A_GEN && bus_wdata[GO_BIT]) |=> core_irq[c]);

      // R2: a pulse never appears without a go write one cycle earlier
      p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
         core_irq[c] |-> $past(wr && bus_addr == A_GEN && bus_wdata[GO_BIT]));

      // R7: non-maskable pulse follows its go write and nothing else
      p_nmi_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && bus_addr == A_NMI && bus_wdata[GO_BIT]) |=> core_nmi[c]);

      p_nmi_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
         core_nmi[c] |-> $past(wr && bus_addr == A_NMI && bus_wdata[GO_BIT]));
   end

   // R6: host pulse follows a go write to the host raise view only
   p_host_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> $past(wr && bus_addr == ADDR_W'(addr_gen(NUM_CORES, NUM_CORES))
                         && bus_wdata[GO_BIT]));
endmodule

bind ipi_regblock ipi_regblock_chk #(
   .NUM_CORES(NUM_CORES),
   .NUM_SRC  (NUM_SRC),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .core_irq (core_irq),
   .core_nmi (core_nmi),
   .host_irq (host_irq),
   .flags_all(flags_all)
);

// File: tb/ipi_regblock_test.sv
module ipi_regblock_test;
   localparam int NC = 4;
   localparam int NS = 28;
   localparam int AW = 6;
   localparam int HOST_GEN = 3 * NC;
   localparam int HOST_ACK = 3 * NC + 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_sel;
   logic          bus_we;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] core_irq;
   logic [NC-1:0] core_nmi;
   logic          host_irq;

   int checks = 0;
   int errors = 0;
   logic [NS-1:0] mflags [NC+1];

   always #5 clk = ~clk;

   ipi_regblock #(.NUM_CORES(NC), .NUM_SRC(NS), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_irq(core_irq), .core_nmi(core_nmi), .host_irq(host_irq));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // channel that a raise/clear address refers to, -1 if none
   function automatic int chan_of(int a);
      if (a < NC) return a;
      if (a < 2 * NC) return a - NC;
      if (a == HOST_GEN || a == HOST_ACK) return NC;
      return -1;
   endfunction

   function automatic logic [31:0] exp_read(int a);
      int ch = chan_of(a);
      if (ch < 0) return 32'h0;
      return {mflags[ch], 4'h0};
   endfunction

   // drive one bus cycle at a falling edge, check pulses at the next one
   task automatic op(bit sel, bit we, int a, logic [31:0] d, string tag);
      logic [NC-1:0] ei = '0;
      logic [NC-1:0] en = '0;
      logic          eh = 1'b0;
      bus_sel = sel; bus_we = we; bus_addr = AW'(a); bus_wdata = d;
      if (sel && !we) begin
         #1;
         chk({tag, " read"}, bus_rdata, exp_read(a));
      end
      if (sel && we) begin
         if (a < NC) begin
            mflags[a] |= d[31:4];
            ei[a] = d[0];
         end else if (a < 2 * NC) begin
            mflags[a-NC] &= ~d[31:4];
         end else if (a < 3 * NC) begin
            en[a-2*NC] = d[0];
         end else if (a == HOST_GEN) begin
            mflags[NC] |= d[31:4];
            eh = d[0];
         end else if (a == HOST_ACK) begin
            mflags[NC] &= ~d[31:4];
         end
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      chk({tag, " pulse"}, 32'({host_irq, core_nmi, core_irq}), 32'({eh, en, ei}));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i <= NC; i++) mflags[i] = '0;
      rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 outputs", 32'({host_irq, core_nmi, core_irq}), 32'h0);
      for (int a = 0; a < 16; a++) op(1, 0, a, 32'h0, "R1");

      // R3 R4: lowest and highest source bits, both views
      op(1, 1, 0, 32'h0000_0010, "R3 src0");
      op(1, 1, 0, 32'h8000_0000, "R3 src27");
      op(1, 0, 0, 32'h0, "R4 raise view");
      op(1, 0, NC, 32'h0, "R4 clear view");
      // R5: clear one flag, go bit set but no pulse expected
      op(1, 1, NC, 32'h0000_0011, "R5 clear src0");
      op(1, 0, 0, 32'h0, "R5 after clear");
      // R2: back-to-back pulses to core 3, then a write with go=0
      op(1, 1, 3, 32'h0000_0001, "R2 first");
      op(1, 1, 3, 32'h0000_0101, "R2 second");
      op(1, 1, 3, 32'h0000_0200, "R2 no go");
      op(1, 0, 3 + NC, 32'h0, "R4 core3 alias");
      // R7 R8: non-maskable pulse and zero read
      op(1, 1, 2 * NC + 1, 32'hFFFF_FFFF, "R7 nmi");
      op(1, 0, 2 * NC + 1, 32'h0, "R8 nmi read");
      // R6: host pair
      op(1, 1, HOST_GEN, 32'h0040_0001, "R6 host raise");
      op(1, 0, HOST_ACK, 32'h0, "R6 host alias");
      op(1, 1, HOST_ACK, 32'h0040_0000, "R6 host clear");
      op(1, 0, HOST_GEN, 32'h0, "R6 host read");
      // R8: unmapped write ignored; R9: unselected write ignored
      op(1, 1, 15, 32'hFFFF_FFFF, "R8 unmapped write");
      op(1, 0, 15, 32'h0, "R8 unmapped read");
      op(0, 1, 1, 32'hFFFF_FFFF, "R9 unselected");
      op(1, 0, 1, 32'h0, "R9 after unselected");

      // constrained random traffic
      for (int n = 0; n < 600; n++) begin
         int a = int'($urandom_range(15, 0));
         logic [31:0] d = $urandom & $urandom & $urandom;
         bit sel = ($urandom_range(9, 0) != 0);
         bit we  = $urandom_range(1, 0) == 1;
         string tag;
         if (!sel)               tag = "R9";
         else if (!we)           tag = "R4";
         else if (a < NC)        tag = "R3";
         else if (a < 2 * NC)    tag = "R5";
         else if (a < 3 * NC)    tag = "R7";
         else if (a <= HOST_ACK) tag = "R6";
         else                    tag = "R8";
         op(sel, we, a, d, tag);
      end

      // final sweep of every word
      for (int a = 0; a < 16; a++) op(1, 0, a, 32'h0, "R4 sweep");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule